// File: doc/BRIEF.md
# MDIO Management Slave with Burst Transfer

This block is the device-side end of a two-wire MII management link. It oversamples the management clock (MDC) and the data line (MDIO) with the system clock, waits for an idle run of ones, then decodes a frame header of start bits, opcode, device address and register address. A frame addressed to this device either reads one 16-bit register, returning it on MDIO through a tri-state driver, or writes one register from the data the station shifts in. The register contents live outside the block and are reached through a small parallel port. That port has an asynchronous read path (`rf_rdata` follows `rf_addr` in the same cycle) and single-cycle write strobes.

When `burst_en` is high, the all-ones register address does not name a register. It starts a burst instead: after the 16 header and turnaround clocks, eleven registers move back to back over 176 data clocks. They go in rising address order, the low group 0 to 5 followed by the high group 16 to 20, so a whole status snapshot can be taken or a full setup loaded in one frame. Burst write data is held in a staging buffer and is written to the register file only once the last data clock of the frame has been seen.

The controller is a single state machine. Its states are S_IDLE (counting idle ones), S_START (second start bit), S_OP, S_PHY, S_REG (header fields), S_TA (turnaround), S_RDATA and S_WDATA (data phase) and S_COMMIT (writing staged words). Its transitions are:
- S_IDLE to S_START on a 0 after a full idle run.
- S_START to S_OP on a 1, and back to S_IDLE on a 0.
- S_OP to S_PHY on a valid opcode, and back to S_IDLE otherwise.
- S_PHY to S_REG after five bits.
- S_REG to S_TA when the device address matches, and to S_IDLE when it does not.
- S_TA to S_RDATA or S_WDATA.
- S_RDATA to S_IDLE after the last word.
- S_WDATA to S_COMMIT after the last word, or to S_IDLE for an ignored write.
- S_COMMIT to S_IDLE after the last staged word.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A start bit is accepted only after at least 32 consecutive ones have been sampled on MDIO since the end of the previous frame. A frame with a shorter idle run before it is ignored entirely.
- R2: The header is the start pair 0 then 1, an opcode (binary 10 = read, 01 = write), a 5-bit device address and a 5-bit register address, all MSB first and sampled on MDC rising edges. Opcodes 00 and 11 cause the frame to be ignored.
- R3: A frame whose device address differs from `phy_strap` never enables the MDIO driver and causes no register write.
- R4: In a read, MDIO stays released during the first turnaround clock, and the block drives 0 for the second turnaround clock.
- R5: A single read returns the 16-bit register MSB first, one bit per MDC clock, each bit changing just after a rising edge. The driver is released after the rising edge that samples the last bit.
- R6: A single write takes 16 bits MSB first and performs exactly one register write, after the last data edge and never before it.
- R7: With `burst_en` low, register address 31 reads as all zeros and a write to it writes nothing.
- R8: With `burst_en` high, a read of address 31 returns eleven words in the order of registers 0, 1, 2, 3, 4, 5, 16, 17, 18, 19, 20, one after another with no gap.
- R9: With `burst_en` high, a write to address 31 writes those eleven registers from the eleven words in the same order. All writes happen after the 192nd clock, and registers 6 to 15 are left unchanged.
- R10: The MDIO driver is released out of reset, and MDIO output or enable only change in the system cycle following a detected MDC rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples MDC |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_i | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Data driven onto MDIO when enabled |
| mdio_oe | output | 1 | Tri-state enable for MDIO |
| phy_strap | input | AW | Device address this block answers to |
| burst_en | input | 1 | Enables the all-ones burst address |
| rf_rd | output | 1 | One-cycle strobe when a register value is taken for output |
| rf_wr | output | 1 | One-cycle register write strobe |
| rf_addr | output | AW | Register address for read and write |
| rf_wdata | output | DW | Register write data |
| rf_rdata | input | DW | Register read data, valid for the current `rf_addr` |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser, a 32-one idle threshold, 16-bit words, and a low group of six plus a high group of five registers starting at 16. These values make the full 192-clock burst and the gap over the reserved addresses 6 to 15 reachable. An MDC period of sixteen system clocks leaves the synchroniser and output register enough margin that every bit the block drives can be checked against the behavioural model in the cycle before the next rising MDC edge. A short preamble of ten ones keeps the count below the idle threshold, so the rejection path is exercised.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_OP,
        S_PHY,
        S_REG,
        S_TA,
        S_RDATA,
        S_WDATA,
        S_COMMIT
    } mdio_state_e;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic mdc_rise,
    output logic sdi
);
    logic [STAGES-1:0] mdc_q;
    logic [STAGES-1:0] dio_q;
    logic              mdc_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_q <= '0;
            dio_q <= '1;
            mdc_d <= 1'b0;
        end else begin
            mdc_q <= {mdc_q[STAGES-2:0], mdc_i};
            dio_q <= {dio_q[STAGES-2:0], mdio_i};
            mdc_d <= mdc_q[STAGES-1];
        end
    end

    assign mdc_rise = mdc_q[STAGES-1] & ~mdc_d;
    assign sdi      = dio_q[STAGES-1];

endmodule

// File: rtl/mdio_idle_det.sv
module mdio_idle_det #(
    parameter int PRE_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic sdi,
    input  logic clr,
    output logic idle_ok
);
    localparam int CW = $clog2(PRE_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(PRE_LEN);

    logic [CW-1:0] ones;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones <= '0;
        end else if (clr) begin
            ones <= '0;
        end else if (rise) begin
            if (!sdi)
                ones <= '0;
            else if (ones != FULL)
                ones <= ones + 1'b1;
        end
    end

    assign idle_ok = (ones == FULL);

endmodule

// File: rtl/mdio_burst_map.sv
module mdio_burst_map #(
    parameter int AW        = 5,
    parameter int IW        = 4,
    parameter int LOW_CNT   = 6,
    parameter int HIGH_BASE = 16
) (
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] addr
);
    localparam logic [IW-1:0] LOW_I = IW'(LOW_CNT);

    always_comb begin
        if (idx < LOW_I)
            addr = AW'(idx);
        else
            addr = AW'(int'(idx) - LOW_CNT + HIGH_BASE);
    end

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
    import mdio_slv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRE_LEN     = 32,
    parameter int AW          = 5,
    parameter int DW          = 16,
    parameter int LOW_CNT     = 6,
    parameter int HIGH_BASE   = 16,
    parameter int HIGH_CNT    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mdc_i,
    input  logic          mdio_i,
    output logic          mdio_o,
    output logic          mdio_oe,
    input  logic [AW-1:0] phy_strap,
    input  logic          burst_en,
    output logic          rf_rd,
    output logic          rf_wr,
    output logic [AW-1:0] rf_addr,
    output logic [DW-1:0] rf_wdata,
    input  logic [DW-1:0] rf_rdata
);
    localparam int NWORDS = LOW_CNT + HIGH_CNT;
    localparam int IW     = $clog2(NWORDS + 1);
    localparam int BW     = $clog2(DW);
    localparam logic [AW-1:0] BURST_ADDR = '1;
    localparam logic [BW-1:0] FLD_LAST   = BW'(AW - 1);
    localparam logic [BW-1:0] DAT_LAST   = BW'(DW - 1);
    localparam logic [IW-1:0] WORD_LAST  = IW'(NWORDS - 1);

    mdio_state_e   state, nxt;
    logic          mdc_rise, sdi, idle_ok, idle_clr;
    logic [BW-1:0] bcnt;
    logic [1:0]    op_q;
    logic [AW-1:0] phy_q, reg_q, map_addr;
    logic          rd_q, burst_q, skip_q;
    logic [IW-1:0] widx, aidx;
    logic [DW-1:0] shreg, rd_word;
    logic [DW-1:0] wbuf [NWORDS];
    logic          last_word, last_commit;
    logic [1:0]    op_now;
    logic [AW-1:0] reg_now;

    mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .mdc_i(mdc_i), .mdio_i(mdio_i),
        .mdc_rise(mdc_rise), .sdi(sdi)
    );

    mdio_idle_det #(.PRE_LEN(PRE_LEN)) u_idle (
        .clk(clk), .rst_n(rst_n), .rise(mdc_rise), .sdi(sdi),
        .clr(idle_clr), .idle_ok(idle_ok)
    );

    mdio_burst_map #(.AW(AW), .IW(IW), .LOW_CNT(LOW_CNT), .HIGH_BASE(HIGH_BASE)) u_map (
        .idx(aidx), .addr(map_addr)
    );

    assign op_now      = {op_q[0], sdi};
    assign reg_now     = {reg_q[AW-2:0], sdi};
    assign last_word   = !burst_q || (widx == WORD_LAST);
    assign last_commit = !burst_q || (aidx == WORD_LAST);
    assign rd_word     = skip_q ? '0 : rf_rdata;

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (mdc_rise && !sdi && idle_ok) nxt = S_START;
            S_START:  if (mdc_rise) nxt = sdi ? S_OP : S_IDLE;
            S_OP:     if (mdc_rise && bcnt == BW'(1))
                          nxt = (op_now == OP_READ || op_now == OP_WRITE) ? S_PHY : S_IDLE;
            S_PHY:    if (mdc_rise && bcnt == FLD_LAST) nxt = S_REG;
            S_REG:    if (mdc_rise && bcnt == FLD_LAST)
                          nxt = (phy_q == phy_strap) ? S_TA : S_IDLE;
            S_TA:     if (mdc_rise && bcnt == BW'(1)) nxt = rd_q ? S_RDATA : S_WDATA;
            S_RDATA:  if (mdc_rise && bcnt == DAT_LAST && last_word) nxt = S_IDLE;
            S_WDATA:  if (mdc_rise && bcnt == DAT_LAST && last_word)
                          nxt = skip_q ? S_IDLE : S_COMMIT;
            S_COMMIT: if (last_commit) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    assign idle_clr = (state != S_IDLE) && (nxt == S_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt    <= '0;
            op_q    <= '0;
            phy_q   <= '0;
            reg_q   <= '0;
            rd_q    <= 1'b0;
            burst_q <= 1'b0;
            skip_q  <= 1'b0;
            widx    <= '0;
            aidx    <= '0;
            shreg   <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else if (state == S_COMMIT) begin
            aidx <= aidx + 1'b1;
        end else if (mdc_rise) begin
            case (state)
                S_IDLE, S_START: bcnt <= '0;
                S_OP: begin
                    op_q <= op_now;
                    if (bcnt == BW'(1)) begin
                        bcnt <= '0;
                        rd_q <= (op_now == OP_READ);
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                S_PHY: begin
                    phy_q <= {phy_q[AW-2:0], sdi};
                    bcnt  <= (bcnt == FLD_LAST) ? '0 : bcnt + 1'b1;
                end
                S_REG: begin
                    reg_q <= reg_now;
                    if (bcnt == FLD_LAST) begin
                        bcnt    <= '0;
                        burst_q <= burst_en && (reg_now == BURST_ADDR);
                        skip_q  <= !burst_en && (reg_now == BURST_ADDR);
                        widx    <= '0;
                        aidx    <= '0;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                S_TA: begin
                    if (bcnt == '0) begin
                        bcnt <= BW'(1);
                        if (rd_q) begin
                            mdio_oe <= 1'b1;
                            mdio_o  <= 1'b0;
                        end
                    end else begin
                        bcnt <= '0;
                        if (rd_q) begin
                            shreg  <= rd_word;
                            mdio_o <= rd_word[DW-1];
                            aidx   <= aidx + 1'b1;
                        end
                    end
                end
                S_RDATA: begin
                    if (bcnt == DAT_LAST) begin
                        bcnt <= '0;
                        if (last_word) begin
                            mdio_oe <= 1'b0;
                            mdio_o  <= 1'b0;
                        end else begin
                            widx   <= widx + 1'b1;
                            shreg  <= rd_word;
                            mdio_o <= rd_word[DW-1];
                            aidx   <= aidx + 1'b1;
                        end
                    end else begin
                        bcnt   <= bcnt + 1'b1;
                        shreg  <= {shreg[DW-2:0], 1'b0};
                        mdio_o <= shreg[DW-2];
                    end
                end
                S_WDATA: begin
                    shreg <= {shreg[DW-2:0], sdi};
                    if (bcnt == DAT_LAST) begin
                        bcnt <= '0;
                        if (last_word) aidx <= '0;
                        else           widx <= widx + 1'b1;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // staging buffer for write words
    always_ff @(posedge clk) begin
        if (mdc_rise && state == S_WDATA && bcnt == DAT_LAST)
            wbuf[widx] <= {shreg[DW-2:0], sdi};
    end

    assign rf_rd = mdc_rise && rd_q && !skip_q &&
                   ((state == S_TA && bcnt == BW'(1)) ||
                    (state == S_RDATA && bcnt == DAT_LAST && !last_word));
    assign rf_wr    = (state == S_COMMIT);
    assign rf_addr  = burst_q ? map_addr : reg_q;
    assign rf_wdata = (aidx < IW'(NWORDS)) ? wbuf[aidx] : '0;

endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mdc_rise,
    input logic          mdio_o,
    input logic          mdio_oe,
    input logic          rf_rd,
    input logic          rf_wr,
    input logic [AW-1:0] rf_addr
);
    // R4
    ta_drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // R10
    oe_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> $past(mdc_rise));

    // R10
    data_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $past(mdc_rise));

    // R5
    fetch_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd |-> mdio_oe);

    // R6
    write_not_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |-> (!mdio_oe && !rf_rd));

    // R7
    no_write_to_burst_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |-> (rf_addr != '1));

endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mdc_rise(mdc_rise), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_addr(rf_addr)
);

// File: tb/mdio_mgmt_slave_bench.sv
module mdio_mgmt_slave_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, mdc, m_oe, m_val, burst_en;
    logic [4:0]  strap = 5'h0B;
    logic        o, oe, rf_rd, rf_wr, bus;
    logic [4:0]  rf_addr;
    logic [15:0] rf_wdata, rf_rdata;
    logic [15:0] regs [32];
    logic [15:0] exp_regs [32];
    logic [15:0] wdat [11];
    int n_cmp = 0, n_bad = 0, wr_pulses = 0;

    assign bus = oe ? o : (m_oe ? m_val : 1'b1);

    mdio_mgmt_slave u_mdio_mgmt_slave (
        .clk(clk), .rst_n(rst_n), .mdc_i(mdc), .mdio_i(bus),
        .mdio_o(o), .mdio_oe(oe), .phy_strap(strap), .burst_en(burst_en),
        .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_addr(rf_addr),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    function automatic logic [15:0] init_val(int i);
        return 16'(i * 16'h0911 + 16'h0123);
    endfunction

    function automatic int addr_of(int w);
        return (w < 6) ? w : w + 10;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) regs[i] <= init_val(i);
        end else if (rf_wr) begin
            regs[rf_addr] <= rf_wdata;
            wr_pulses     <= wr_pulses + 1;
        end
    end
    assign rf_rdata = regs[rf_addr];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bit_cycle(input bit men, input bit mval, input bit eoe,
                             input bit eval, input string req);
        @(negedge clk);
        mdc = 1'b0; m_oe = men; m_val = mval;
        repeat (7) @(negedge clk);
        check(oe === eoe, req, "mdio_oe", int'(oe), int'(eoe));
        if (eoe) check(bus === eval, req, "mdio data", int'(bus), int'(eval));
        @(negedge clk);
        mdc = 1'b1;
        repeat (7) @(negedge clk);
    endtask

    task automatic frame(input int pre, input bit [1:0] op, input bit [4:0] phy,
                         input bit [4:0] ra, input string req);
        bit valid_op = (op == 2'b10) || (op == 2'b01);
        bit rd       = (op == 2'b10);
        bit resp     = (pre >= 32) && valid_op && (phy == strap);
        bit burst    = burst_en && (ra == 5'd31);
        int nw       = burst ? 11 : 1;
        int w0       = wr_pulses;
        int exp_wr   = 0;
        bit [13:0] hdr = {2'b01, op, phy, ra};
        logic [15:0] ew;
        for (int i = 0; i < pre; i++) bit_cycle(1'b1, 1'b1, 1'b0, 1'b0, req);
        for (int i = 13; i >= 0; i--) bit_cycle(1'b1, hdr[i], 1'b0, 1'b0, req);
        if (rd) begin
            bit_cycle(1'b0, 1'b0, 1'b0, 1'b0, req);
            bit_cycle(1'b0, 1'b0, resp, 1'b0, req);
        end else begin
            bit_cycle(1'b1, 1'b1, 1'b0, 1'b0, req);
            bit_cycle(1'b1, 1'b0, 1'b0, 1'b0, req);
        end
        for (int w = 0; w < nw; w++) begin
            if (burst)            ew = exp_regs[addr_of(w)];
            else if (ra == 5'd31) ew = 16'h0000;
            else                  ew = exp_regs[ra];
            for (int b = 15; b >= 0; b--) begin
                if (!rd && w == nw - 1 && b == 0)
                    check(wr_pulses == w0, req, "write before frame end", wr_pulses - w0, 0);
                if (rd) bit_cycle(1'b0, 1'b0, resp, ew[b], req);
                else    bit_cycle(1'b1, wdat[w][b], 1'b0, 1'b0, req);
            end
        end
        bit_cycle(1'b0, 1'b0, 1'b0, 1'b0, req);
        bit_cycle(1'b0, 1'b0, 1'b0, 1'b0, req);
        if (!rd && resp) begin
            if (burst) begin
                for (int w = 0; w < 11; w++) exp_regs[addr_of(w)] = wdat[w];
                exp_wr = 11;
            end else if (ra != 5'd31) begin
                exp_regs[ra] = wdat[0];
                exp_wr = 1;
            end
        end
        check(wr_pulses - w0 == exp_wr, req, "write count", wr_pulses - w0, exp_wr);
        for (int i = 0; i < 32; i++)
            check(regs[i] === exp_regs[i], req, $sformatf("reg %0d", i),
                  int'(regs[i]), int'(exp_regs[i]));
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) exp_regs[i] = init_val(i);
        rst_n = 1'b0; mdc = 1'b0; m_oe = 1'b1; m_val = 1'b1; burst_en = 1'b0;
        repeat (5) @(negedge clk);
        // R10 reset state
        check(oe === 1'b0, "R10", "reset oe", int'(oe), 0);
        check(rf_wr === 1'b0 && rf_rd === 1'b0, "R10", "reset strobes", int'(rf_wr), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        wdat[0] = 16'hA5C3;
        frame(32, 2'b01, 5'h0B, 5'd4, "R6");
        frame(32, 2'b10, 5'h0B, 5'd4, "R5");
        wdat[0] = 16'h8001;
        frame(32, 2'b01, 5'h0B, 5'd17, "R6");
        frame(32, 2'b10, 5'h0B, 5'd17, "R4");
        wdat[0] = 16'h0F0F;
        frame(32, 2'b01, 5'h0A, 5'd4, "R3");
        frame(32, 2'b10, 5'h1B, 5'd4, "R3");
        wdat[0] = 16'h1234;
        frame(10, 2'b01, 5'h0B, 5'd4, "R1");
        frame(32, 2'b10, 5'h0B, 5'd4, "R1");
        frame(32, 2'b11, 5'h0B, 5'd4, "R2");
        frame(32, 2'b00, 5'h0B, 5'd4, "R2");
        frame(32, 2'b01, 5'h0B, 5'd31, "R7");
        frame(32, 2'b10, 5'h0B, 5'd31, "R7");
        burst_en = 1'b1;
        for (int w = 0; w < 11; w++) wdat[w] = 16'(16'hC000 + w * 16'h0101);
        frame(32, 2'b01, 5'h0B, 5'd31, "R9");
        frame(32, 2'b10, 5'h0B, 5'd31, "R8");
        frame(32, 2'b10, 5'h0B, 5'd7, "R9");
        finish_run();
    end
endmodule